// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Fast-Set

This block holds the time of day as three packed BCD digit pairs (hours, minutes, seconds) ready for a six-digit display. A one-pulse-per-second tick advances the seconds. The seconds carry into the minutes, and the minutes carry into the hours. The hours run on a 24-hour cycle.

Two level inputs let a user adjust the time. One selects the hours and one selects the minutes. On every pulse of a separate, faster set tick, each selected field advances by one and wraps within its own range. A set step never carries into a neighbouring field and never raises a strobe. Two one-cycle strobes mark the top of each minute and the top of each hour. Display multiplexing, segment decoding, debouncing and clock division all live outside this block.

Top module: `tod_bcd_clock`

## Requirements
- R1: The hour field counts 00 to 23 in BCD. A seconds tick at 23:59:59 yields 00:00:00, and the hour field never exceeds 0x23.
- R2: The minute field counts 00 to 59. A seconds tick while seconds are 59 advances minutes by one, and minutes wrap from 59 to 00.
- R3: The seconds field advances by exactly one on each `sec_tick` and holds otherwise. It wraps from 59 to 00 and is never altered by the set inputs.
- R4: Each field is one byte. Bits [7:4] hold the tens digit and bits [3:0] hold the units digit. A units digit of 9 rolls to 0 and increments the tens digit, so the units digit never exceeds 9.
- R5: When `set_tick` is high, `hour_set` high advances hours by one, wrapping 23 to 00. Minutes and seconds are left unchanged and no strobe is raised.
- R6: When `set_tick` is high, `min_set` high advances minutes by one, wrapping 59 to 00. No carry reaches the hours and no strobe is raised.
- R7: A seconds carry and a minute set step in the same cycle are both applied, giving +2 on minutes. Only the carry path can propagate into hours, so minute 58 at that moment becomes 00 with no hour change.
- R8: `minute_strobe` is high for exactly the one cycle in which the outputs first show the seconds-driven rollover to :00.
- R9: `hour_strobe` is high for exactly the one cycle in which the outputs first show a seconds-driven rollover to mm:ss = 00:00, and it is always accompanied by `minute_strobe`.
- R10: `rst_n` low at a rising clock edge loads 00:00:00 and clears both strobes, whatever the other inputs are.
- R11: While `set_tick` is low, `hour_set` and `min_set` have no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per second |
| set_tick | input | 1 | One-cycle pulse at the fast set rate |
| hour_set | input | 1 | Level: step hours on each set tick |
| min_set | input | 1 | Level: step minutes on each set tick |
| hours_bcd | output | 8 | Hours, tens in [7:4], units in [3:0] |
| minutes_bcd | output | 8 | Minutes, tens in [7:4], units in [3:0] |
| seconds_bcd | output | 8 | Seconds, tens in [7:4], units in [3:0] |
| minute_strobe | output | 1 | One-cycle top-of-minute pulse |
| hour_strobe | output | 1 | One-cycle top-of-hour pulse |

## Verification
The bench builds the block with its default moduli: 24 for hours and 60 for minutes and seconds. Because the seconds tick can pulse on every clock, a full 86,400-tick day fits easily into one run. That run checks the final wrap to midnight and the exact counts of 1,440 minute strobes and 24 hour strobes. Set steps on every cycle reach the 23:59 and minute-58 corners in a few dozen cycles, which leaves the concurrent carry-and-set case cheap to exercise.

// File: rtl/tod_pkg.sv
// Shared types and helpers for the time-of-day counter.
// Assumes every field modulus lies between 2 and 100.
package tod_pkg;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd_pair_t;

    localparam bcd_pair_t BCD_ZERO = '{tens: 4'd0, units: 4'd0};

    // Next value of a two-digit BCD counter running modulo `modulo`.
    function automatic bcd_pair_t bcd_next(bcd_pair_t v, int unsigned modulo);
        bcd_pair_t r;
        if (v.tens == 4'((modulo - 1) / 10) && v.units == 4'((modulo - 1) % 10)) begin
            r = BCD_ZERO;
        end else if (v.units == 4'd9) begin
            r.tens  = v.tens + 4'd1;
            r.units = 4'd0;
        end else begin
            r.tens  = v.tens;
            r.units = v.units + 4'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tod_bcd_field.sv
// One two-digit BCD field (hours, minutes or seconds).
// A carry step and an optional set step may both arrive in one cycle;
// each advances the field by one. Only a carry step taken at the last
// value raises `carry_out`, so set steps never ripple into a neighbour.
// Assumes the parent drives the steps from registered state.
module tod_bcd_field
    import tod_pkg::*;
#(
    parameter int unsigned MODULO  = 60,
    parameter bit          HAS_SET = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      carry_step,
    input  logic      set_step,
    output bcd_pair_t value,
    output logic      carry_out
);

    localparam int unsigned LAST_TENS  = (MODULO - 1) / 10;
    localparam int unsigned LAST_UNITS = (MODULO - 1) % 10;

    logic      set_eff;
    logic      at_last;
    bcd_pair_t after_carry;
    bcd_pair_t after_set;

    // Select whether this field accepts set steps at all.
    generate
        if (HAS_SET) begin : g_set
            assign set_eff = set_step;
        end else begin : g_noset
            logic unused_set;
            assign unused_set = set_step;
            assign set_eff    = 1'b0;
        end
    endgenerate

    // Detect the last value of the field's range.
    assign at_last = (value.tens == 4'(LAST_TENS)) && (value.units == 4'(LAST_UNITS));

    // Apply the carry step first, then the set step on top of it.
    always_comb begin
        after_carry = carry_step ? bcd_next(value, MODULO) : value;
        after_set   = set_eff ? bcd_next(after_carry, MODULO) : after_carry;
    end

    assign carry_out = carry_step && at_last;

    // Field register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= BCD_ZERO;
        end else begin
            value <= after_set;
        end
    end

    AST_UNITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        value.units <= 4'd9);  // R4

    AST_FIELD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({4'd0, value.tens} * 8'd10 + {4'd0, value.units}) < 8'(MODULO));  // R4

    AST_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_step && !set_eff) |=> $stable(value));  // R11

endmodule

// File: rtl/tod_rollover_strobes.sv
// Registers the top-of-minute and top-of-hour pulses so that each one
// lines up with the first cycle that shows the rolled-over time.
// Assumes both roll inputs come from carry paths only.
module tod_rollover_strobes (
    input  logic clk,
    input  logic rst_n,
    input  logic minute_roll,
    input  logic hour_roll,
    output logic minute_strobe,
    output logic hour_strobe
);

    // Capture the rollovers as single-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            minute_strobe <= 1'b0;
            hour_strobe   <= 1'b0;
        end else begin
            minute_strobe <= minute_roll;
            hour_strobe   <= hour_roll;
        end
    end

    AST_HOUR_WITH_MINUTE: assert property (@(posedge clk) disable iff (!rst_n)
        hour_strobe |-> minute_strobe);  // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        minute_strobe |=> !minute_strobe);  // R8

endmodule

// File: rtl/tod_bcd_clock.sv
// Time-of-day counter: BCD hours, minutes and seconds with fast-set.
// Seconds advance on sec_tick. Hour and minute set inputs step their
// field on set_tick without carrying. Both strobes are one cycle long.
// Assumes sec_tick and set_tick are single-cycle pulses in the clk domain.
module tod_bcd_clock
    import tod_pkg::*;
#(
    parameter int unsigned HOURS_MOD   = 24,
    parameter int unsigned MINUTES_MOD = 60,
    parameter int unsigned SECONDS_MOD = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       set_tick,
    input  logic       hour_set,
    input  logic       min_set,
    output logic [7:0] hours_bcd,
    output logic [7:0] minutes_bcd,
    output logic [7:0] seconds_bcd,
    output logic       minute_strobe,
    output logic       hour_strobe
);

    bcd_pair_t sec_val, min_val, hour_val;
    logic      sec_carry, min_carry, hour_carry;
    logic      min_set_step, hour_set_step;

    // Gate the set levels with the set-rate tick.
    assign min_set_step  = set_tick && min_set;
    assign hour_set_step = set_tick && hour_set;

    tod_bcd_field #(.MODULO(SECONDS_MOD), .HAS_SET(1'b0)) u_sec (
        .clk(clk), .rst_n(rst_n), .carry_step(sec_tick), .set_step(1'b0),
        .value(sec_val), .carry_out(sec_carry)
    );

    tod_bcd_field #(.MODULO(MINUTES_MOD), .HAS_SET(1'b1)) u_min (
        .clk(clk), .rst_n(rst_n), .carry_step(sec_carry), .set_step(min_set_step),
        .value(min_val), .carry_out(min_carry)
    );

    tod_bcd_field #(.MODULO(HOURS_MOD), .HAS_SET(1'b1)) u_hour (
        .clk(clk), .rst_n(rst_n), .carry_step(min_carry), .set_step(hour_set_step),
        .value(hour_val), .carry_out(hour_carry)
    );

    logic unused_hour_carry;
    assign unused_hour_carry = hour_carry;

    tod_rollover_strobes u_strobes (
        .clk(clk), .rst_n(rst_n), .minute_roll(sec_carry), .hour_roll(min_carry),
        .minute_strobe(minute_strobe), .hour_strobe(hour_strobe)
    );

    assign hours_bcd   = hour_val;
    assign minutes_bcd = min_val;
    assign seconds_bcd = sec_val;

    AST_HOUR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        hours_bcd <= 8'h23);  // R1

    AST_SECONDS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(seconds_bcd));  // R3

    AST_SET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> (!minute_strobe && !hour_strobe));  // R5 R6

    AST_MINUTE_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        minute_strobe |-> (seconds_bcd == 8'h00));  // R8

endmodule

// File: tb/test_tod_bcd_clock.sv
`timescale 1ns/1ps
module test_tod_bcd_clock;

    logic       clk = 1'b0;
    logic       rst_n, sec_tick, set_tick, hour_set, min_set;
    logic [7:0] hours_bcd, minutes_bcd, seconds_bcd;
    logic       minute_strobe, hour_strobe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tod_bcd_clock i_tod_bcd_clock (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_tick(set_tick),
        .hour_set(hour_set), .min_set(min_set), .hours_bcd(hours_bcd),
        .minutes_bcd(minutes_bcd), .seconds_bcd(seconds_bcd),
        .minute_strobe(minute_strobe), .hour_strobe(hour_strobe)
    );

    // Vector: [29]tick [28]set_tick [27]hour_set [26]min_set
    //         [25:18]hours [17:10]minutes [9:2]seconds [1]min strobe [0]hour strobe
    localparam int NVEC = 8;
    localparam logic [29:0] VEC [NVEC] = '{
        {4'b1000, 8'h00, 8'h00, 8'h01, 2'b00},   // R3 tick
        {4'b0110, 8'h01, 8'h00, 8'h01, 2'b00},   // R5 hour step
        {4'b0101, 8'h01, 8'h01, 8'h01, 2'b00},   // R6 minute step
        {4'b0111, 8'h02, 8'h02, 8'h01, 2'b00},   // R5 R6 both fields
        {4'b1011, 8'h02, 8'h02, 8'h02, 2'b00},   // R11 levels without set tick
        {4'b1101, 8'h02, 8'h03, 8'h03, 2'b00},   // R7 tick and minute step
        {4'b0110, 8'h03, 8'h03, 8'h03, 2'b00},   // R5 no tick
        {4'b0000, 8'h03, 8'h03, 8'h03, 2'b00}    // R11 idle hold
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs at a falling edge; return at the next falling edge.
    task automatic cyc(input logic tk, input logic st, input logic hs, input logic ms);
        sec_tick = tk; set_tick = st; hour_set = hs; min_set = ms;
        @(negedge clk);
    endtask

    function automatic logic [25:0] snap();
        return {hours_bcd, minutes_bcd, seconds_bcd, minute_strobe, hour_strobe};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int any_strobe;
        int ms_count;
        int hs_count;
        rst_n = 1'b0;
        sec_tick = 1'b1; set_tick = 1'b1; hour_set = 1'b1; min_set = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset state", 32'(snap()), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26]);
            check($sformatf("R3/R5/R6/R7/R11 vector %0d", i), 32'(snap()), 32'(VEC[i][25:0]));
        end

        rst_n = 1'b0; cyc(0, 0, 0, 0); rst_n = 1'b1;
        check("R10 reset after table", 32'(snap()), 32'h0);

        repeat (10) cyc(1, 0, 0, 0);
        check("R4 units roll to tens", 32'(seconds_bcd), 32'h10);
        repeat (49) cyc(1, 0, 0, 0);
        check("R3 seconds at 59", 32'(snap()), {8'h00, 8'h00, 8'h59, 2'b00});
        cyc(1, 0, 0, 0);
        check("R8 R2 minute rollover", 32'(snap()), {8'h00, 8'h01, 8'h00, 2'b10});
        cyc(0, 0, 0, 0);
        check("R8 strobe one cycle", 32'(minute_strobe), 32'h0);

        any_strobe = 0;
        for (int i = 0; i < 58; i++) begin
            cyc(0, 1, 0, 1);
            any_strobe += int'(minute_strobe) + int'(hour_strobe);
        end
        check("R6 minute set to 59", 32'(snap()), {8'h00, 8'h59, 8'h00, 2'b00});
        check("R6 no strobe from set", 32'(any_strobe), 32'h0);
        cyc(0, 1, 0, 1);
        check("R6 minute wrap no hour carry", 32'(snap()), {8'h00, 8'h00, 8'h00, 2'b00});

        repeat (23) cyc(0, 1, 1, 0);
        repeat (59) cyc(0, 1, 0, 1);
        check("R5 set to 23:59", 32'(snap()), {8'h23, 8'h59, 8'h00, 2'b00});
        cyc(0, 1, 1, 0);
        check("R5 hour wrap 23 to 00", 32'(snap()), {8'h00, 8'h59, 8'h00, 2'b00});
        repeat (23) cyc(0, 1, 1, 0);
        repeat (59) cyc(1, 0, 0, 0);
        check("R1 at 23:59:59", 32'(snap()), {8'h23, 8'h59, 8'h59, 2'b00});
        cyc(1, 0, 0, 0);
        check("R1 R9 midnight rollover", 32'(snap()), {8'h00, 8'h00, 8'h00, 2'b11});

        repeat (58) cyc(0, 1, 0, 1);
        repeat (59) cyc(1, 0, 0, 0);
        check("R7 setup 00:58:59", 32'(snap()), {8'h00, 8'h58, 8'h59, 2'b00});
        cyc(1, 1, 0, 1);
        check("R7 carry plus set", 32'(snap()), {8'h00, 8'h00, 8'h00, 2'b10});

        repeat (5) cyc(1, 0, 0, 0);
        rst_n = 1'b0;
        cyc(1, 1, 1, 1);
        check("R10 reset mid-run", 32'(snap()), 32'h0);
        rst_n = 1'b1;

        ms_count = 0; hs_count = 0;
        for (int i = 0; i < 86400; i++) begin
            cyc(1, 0, 0, 0);
            ms_count += int'(minute_strobe);
            hs_count += int'(hour_strobe);
        end
        check("R1 R2 R3 full day back to midnight", 32'(snap()), {8'h00, 8'h00, 8'h00, 2'b11});
        check("R8 minute strobes per day", 32'(ms_count), 32'd1440);
        check("R9 hour strobes per day", 32'(hs_count), 32'd24);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule